// File: doc/BRIEF.md
# Sample packer with beat FIFO

This block takes one narrow two's-complement sample on every clock once a capture is running. It widens each sample to a 16-bit lane by sign extension and packs consecutive lanes into wide beats. The sample has `SAMPLE_W` bits and a beat has `BEAT_W` bits. Each completed beat goes into a small internal FIFO. The FIFO drains through a valid/ready stream interface.

A capture is started with a single-cycle `start` pulse, which loads a beat count from `frames`. Once the block has built that many beats, it stops taking samples. The `busy` output stays high until the FIFO has also emptied. If a completed beat finds the FIFO full, the beat is lost and a sticky `overflow` flag is raised.

Top module: `sample_beat_packer`

## Requirements
- R1: While reset is asserted (`rst_n` = 0) and after it is released, `out_valid`, `busy` and `overflow` are 0 until a capture starts.
- R2: A `start` pulse begins a capture only when `busy` is 0 and `frames` is nonzero. The first sample is taken on the clock edge after the one that registers `start`. A `start` while busy, or a `start` with `frames` = 0, has no effect.
- R3: Each lane holds the sample sign-extended from `SAMPLE_W` bits to 16 bits. Bits above the sample copy bit `SAMPLE_W-1`.
- R4: The first sample of a beat sits in bits [15:0] (lane 0). The k-th later sample sits in bits [16k+15:16k]. A beat holds `BEAT_W/16` lanes.
- R5: A beat is written into the FIFO on the edge that captures its last lane. If the FIFO was empty, `out_valid` is 1 in the following cycle. Exactly `frames` beats are built per capture.
- R6: Beats leave the FIFO in the order they were built, one on each edge where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold.
- R7: A beat that completes while the FIFO holds `DEPTH` beats and no beat is leaving is dropped and sets `overflow`. The dropped beat still counts toward `frames`. `overflow` stays 1 until the next accepted `start`.
- R8: A beat that completes while the FIFO is full, on the same edge that a beat leaves, is stored. `overflow` does not change.
- R9: `busy` is 1 from the edge that accepts `start` until the last beat is built and the FIFO is empty. When `busy` is 0, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture start pulse |
| frames | input | FRAME_W | Number of beats to build |
| sample | input | SAMPLE_W | Signed sample, taken every cycle during capture |
| out_valid | output | 1 | FIFO head holds a beat |
| out_ready | input | 1 | Sink accepts the head beat |
| out_data | output | BEAT_W | Head beat |
| busy | output | 1 | Capture running or FIFO not empty |
| overflow | output | 1 | Sticky beat-loss flag |

## Verification
Two events can land on the same edge: completion of a beat and a pop from a full FIFO. The bench fills the FIFO with `out_ready` held low. It then raises `out_ready` for exactly one cycle, on the edge where the next beat completes. The drained stream must then show every beat with `overflow` still 0. Moving that single-cycle ready pulse one edge later must drop exactly that beat and raise `overflow`.

// File: rtl/sample_beat_packer.sv
module sample_beat_packer #(
  parameter int SAMPLE_W = 12,
  parameter int BEAT_W   = 64,
  parameter int DEPTH    = 4,
  parameter int FRAME_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [FRAME_W-1:0]  frames,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [BEAT_W-1:0]   out_data,
  output logic                busy,
  output logic                overflow
);
  localparam int LANES = BEAT_W / 16;
  localparam int LW    = $clog2(LANES);
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic               capturing;
  logic [LW-1:0]      lane;
  logic [FRAME_W-1:0] beats_left;
  logic [BEAT_W-17:0] acc;
  logic [BEAT_W-1:0]  mem [DEPTH];
  logic [PW-1:0]      wr_ptr, rd_ptr;
  logic [CW-1:0]      count;

  wire [15:0] ext       = {{(16-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
  wire        beat_done = capturing && (lane == LW'(LANES-1));
  wire        pop       = out_valid && out_ready;
  wire        room      = (count != CW'(DEPTH)) || pop;
  wire        push      = beat_done && room;
  wire        go        = start && !busy && (frames != '0);

  assign out_valid = (count != '0);
  assign busy      = capturing || out_valid;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capturing  <= 1'b0;
      lane       <= '0;
      beats_left <= '0;
      overflow   <= 1'b0;
    end else if (go) begin
      capturing  <= 1'b1;
      lane       <= '0;
      beats_left <= frames;
      overflow   <= 1'b0;
    end else if (capturing) begin
      if (beat_done) begin
        lane       <= '0;
        beats_left <= beats_left - 1'b1;
        if (beats_left == FRAME_W'(1)) capturing <= 1'b0;
        if (!room) overflow <= 1'b1;
      end else begin
        lane <= lane + LW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (capturing && !beat_done) acc[int'(lane)*16 +: 16] <= ext;
    if (push) mem[wr_ptr] <= {ext, acc};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(beat_done && count == CW'(DEPTH) && !out_ready));

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && frames != '0 |=> busy && !overflow);

  // R5
  frame_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capturing |-> beats_left != '0);
endmodule

// File: tb/sample_beat_packer_tb_top.sv
`timescale 1ns/1ps
module sample_beat_packer_tb_top;
  localparam int SW = 12, BW = 64, D = 4, FW = 16, L = BW / 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] frames = '0;
  logic [SW-1:0] sample = '0;
  logic          out_ready = 1'b0;
  logic          out_valid, busy, overflow;
  logic [BW-1:0] out_data;

  int vec = 0, bad = 0, t = 0, t0 = 0;
  int exp_list [32];
  int exp_n = 0, exp_p = 0;

  always #2.5 clk = ~clk;

  sample_beat_packer #(.SAMPLE_W(SW), .BEAT_W(BW), .DEPTH(D), .FRAME_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frames(frames), .sample(sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy), .overflow(overflow));

  function automatic logic [SW-1:0] f(int n);
    return SW'(n * 1237 + 5);
  endfunction

  function automatic logic [BW-1:0] expb(int base, int b);
    logic [BW-1:0] r;
    for (int j = 0; j < L; j++) begin
      logic [SW-1:0] s;
      s = f(base + 1 + b * L + j);
      r[16*j +: 16] = {{(16-SW){s[SW-1]}}, s};
    end
    return r;
  endfunction

  task automatic chk(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(bit rdy, bit st);
    @(negedge clk);
    t++;
    sample    = f(t);
    start     = st;
    out_ready = rdy;
    if (out_valid && rdy) begin
      if (exp_p >= exp_n) chk("R5 R7 extra beat", 1, 0);
      else chk("R3 R4 R6 beat content", out_data, expb(t0, exp_list[exp_p]));
      exp_p++;
    end
  endtask

  task automatic set_exp(int n);
    for (int i = 0; i < n; i++) exp_list[i] = i;
    exp_n = n;
    exp_p = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && busy; i++) cyc(1'b1, 1'b0);
    chk("R9 busy clears", busy, 0);
    chk("R9 idle no valid", out_valid, 0);
  endtask

  task automatic run(int fr, int mode, int restart_at);
    set_exp(fr);
    frames = FW'(fr);
    cyc(1'b1, 1'b1);
    t0 = t;
    for (int i = 0; i < 400; i++) begin
      bit r;
      r = (mode == 0) ? 1'b1 : (mode == 1) ? bit'(i % 2) : bit'(i % 3 == 2);
      cyc(r, i == restart_at);
      if (!busy) break;
    end
    chk("R9 busy clears", busy, 0);
    chk("R5 beat count", exp_p, fr);
    chk("R7 no overflow", overflow, 0);
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) cyc(1'b0, 1'b0);
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset overflow", overflow, 0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R1 after reset busy", busy, 0);

    // R2 zero frames ignored
    frames = '0;
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    chk("R2 zero frames busy", busy, 0);
    chk("R2 zero frames valid", out_valid, 0);

    // R5 R6 sweep over frame counts and ready patterns
    for (int fr = 1; fr <= 6; fr++)
      for (int m = 0; m < 3; m++) run(fr, m, -1);

    // R2 start while busy ignored
    run(3, 0, 2);
    run(5, 1, 7);

    // R7 overflow, R5 push timing, R6 hold
    set_exp(D);
    frames = FW'(6);
    cyc(1'b0, 1'b1);
    t0 = t;
    for (int i = 0; i < 6 * L + 3; i++) begin
      cyc(1'b0, 1'b0);
      if (t == t0 + L) chk("R5 not yet valid", out_valid, 0);
      if (t == t0 + L + 1) chk("R5 valid after first beat", out_valid, 1);
      if (t == t0 + L + 2) chk("R6 head held", out_data, expb(t0, 0));
    end
    chk("R7 overflow set", overflow, 1);
    chk("R7 capture ended", busy, 1);
    drain();
    chk("R7 dropped beats counted", exp_p, D);
    chk("R7 overflow sticky", overflow, 1);
    run(1, 0, -1);
    chk("R7 overflow cleared by start", overflow, 0);

    // R8 completion and pop on the same edge, then one edge late (R7)
    for (int late = 0; late < 2; late++) begin
      int tgt;
      set_exp(late ? D : D + 1);
      frames = FW'(D + 1);
      cyc(1'b0, 1'b1);
      t0 = t;
      tgt = t0 + (D + 1) * L + late;
      for (int i = 0; i < (D + 1) * L + 4; i++) cyc(t + 1 == tgt, 1'b0);
      chk(late ? "R7 late pop overflow" : "R8 same edge no overflow", overflow, late);
      drain();
      chk(late ? "R7 late pop beats" : "R8 same edge beats", exp_p, late ? D : D + 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule